// File: doc/BRIEF.md
# Dual-Clock Byte-Lane Pipelined RAM

This block is a true dual-port synchronous memory. Two ports, A and B, each have their own clock and can reach every word of one shared array at the same time. A word is eighteen bits wide. It is split into two nine-bit lanes, and each lane has its own active-low write and read enable. Each port samples its address, write data and controls on the rising edge of its own clock. Read data leaves through a registered output stage, so what a port presents in a given cycle is decided by the controls it sampled one cycle earlier.

A port is selected through two chip selects of opposite polarity, which allows banks of these memories to be decoded for depth expansion without extra logic. Per-lane drive flags take the place of three-state pads. When a flag is low, the matching lane of the read bus reads as zero. An asynchronous output enable clears both flags without waiting for a clock. The depth is set by a parameter, and a fifteen-bit address gives the full 32K-word array.

Top module: `dpram_bytelane`

## Requirements
- R1: A port counts as selected only when its `cs0_n` is 0 and its `cs1` is 1. With any other pair of values, a write has no effect on the array, and the drive flags for the following cycle stay at 0.
- R2: A selected write (`rd_wr_n` = 0) updates only the enabled lanes. The lower lane is bits 8..0, enabled by `lo_en_n` = 0. The upper lane is bits 17..9, enabled by `hi_en_n` = 0. Writing the lower lane only, the upper lane only, or both lanes is allowed.
- R3: A selected read (`rd_wr_n` = 1) whose address is sampled on clock edge k presents the stored word on `rdata` from edge k+1 until edge k+2.
- R4: Each lane's drive flag follows that lane's enable from the previous sampled cycle of a selected read. A lane whose flag is 0 reads as zero on `rdata`.
- R5: While `oe_n` is 1, both drive flags of that port are 0 and `rdata` is zero, with no clock edge needed. Returning `oe_n` to 0 brings the registered lanes back.
- R6: A write reaches every read sampled on a later edge, whether that read is on the same port or on the other port. A read sampled on the same edge as the other port's write to that address returns the old word.
- R7: If both ports write the same address on the same edge, port A's data lands in the lanes both ports enable. Each lane enabled by only one port takes that port's data.
- R8: While `rst_n` is 0, and after it is released, all drive flags are 0 and both read buses are zero until a selected read has passed through the pipeline.
- R9: The cycle after a sampled write shows no drive on that port's lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers of both ports |
| a_clk | input | 1 | Port A clock |
| a_cs0_n | input | 1 | Port A chip select, active low |
| a_cs1 | input | 1 | Port A chip select, active high |
| a_rd_wr_n | input | 1 | Port A direction: 1 = read, 0 = write |
| a_hi_en_n | input | 1 | Port A upper lane enable, active low |
| a_lo_en_n | input | 1 | Port A lower lane enable, active low |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, zero in undriven lanes |
| a_drv_lo | output | 1 | Port A lower lane is driven |
| a_drv_hi | output | 1 | Port A upper lane is driven |
| b_clk | input | 1 | Port B clock |
| b_cs0_n | input | 1 | Port B chip select, active low |
| b_cs1 | input | 1 | Port B chip select, active high |
| b_rd_wr_n | input | 1 | Port B direction: 1 = read, 0 = write |
| b_hi_en_n | input | 1 | Port B upper lane enable, active low |
| b_lo_en_n | input | 1 | Port B lower lane enable, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data, zero in undriven lanes |
| b_drv_lo | output | 1 | Port B lower lane is driven |
| b_drv_hi | output | 1 | Port B upper lane is driven |

## Verification
If a write commits late, is lost, or lands in the wrong lane, the fault stays hidden until a read of that word. The bench therefore reads back every written word, on both ports, one edge later. A pipeline stage off by one shows up as a lane flag or data word shifted by a full cycle. Because every cycle's output is compared against the slot due in that cycle, such a shift is caught at the first read. A wrong collision order appears only on a word that both ports wrote on the same edge, so those words are read back at once.

// File: rtl/dpram_bytelane.sv
module dpram_bytelane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_cs0_n,
  input  logic              a_cs1,
  input  logic              a_rd_wr_n,
  input  logic              a_hi_en_n,
  input  logic              a_lo_en_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_drv_lo,
  output logic              a_drv_hi,
  input  logic              b_clk,
  input  logic              b_cs0_n,
  input  logic              b_cs1,
  input  logic              b_rd_wr_n,
  input  logic              b_hi_en_n,
  input  logic              b_lo_en_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic              b_drv_lo,
  output logic              b_drv_hi
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  logic              a_sel, b_sel;
  logic              a_sel_q, b_sel_q, a_rd_q, b_rd_q;
  logic [1:0]        a_lane_q, b_lane_q, a_ovld, b_ovld;
  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic [WORD_W-1:0] a_wd_q, b_wd_q, a_oq, b_oq;
  logic              a_tog, b_tog, a_ack, b_ack;

  assign a_sel = ~a_cs0_n & a_cs1;
  assign b_sel = ~b_cs0_n & b_cs1;

  always_ff @(posedge a_clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sel_q  <= 1'b0;
      a_rd_q   <= 1'b1;
      a_lane_q <= 2'b00;
      a_addr_q <= '0;
      a_wd_q   <= '0;
      a_tog    <= 1'b0;
      a_ovld   <= 2'b00;
      a_oq     <= '0;
    end else begin
      a_sel_q  <= a_sel;
      a_rd_q   <= a_rd_wr_n;
      a_lane_q <= ~{a_hi_en_n, a_lo_en_n};
      a_addr_q <= a_addr;
      a_wd_q   <= a_wdata;
      if (a_sel && !a_rd_wr_n) a_tog <= ~a_tog;
      a_ovld   <= (a_sel_q && a_rd_q) ? a_lane_q : 2'b00;
      a_oq     <= mem[a_addr_q];
    end
  end

  always_ff @(posedge b_clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sel_q  <= 1'b0;
      b_rd_q   <= 1'b1;
      b_lane_q <= 2'b00;
      b_addr_q <= '0;
      b_wd_q   <= '0;
      b_tog    <= 1'b0;
      b_ovld   <= 2'b00;
      b_oq     <= '0;
    end else begin
      b_sel_q  <= b_sel;
      b_rd_q   <= b_rd_wr_n;
      b_lane_q <= ~{b_hi_en_n, b_lo_en_n};
      b_addr_q <= b_addr;
      b_wd_q   <= b_wdata;
      if (b_sel && !b_rd_wr_n) b_tog <= ~b_tog;
      b_ovld   <= (b_sel_q && b_rd_q) ? b_lane_q : 2'b00;
      b_oq     <= mem[b_addr_q];
    end
  end

  always_ff @(posedge a_clk or posedge b_clk) begin
    if (!rst_n) begin
      a_ack <= 1'b0;
      b_ack <= 1'b0;
    end else begin
      if (b_tog != b_ack) begin
        b_ack <= b_tog;
        if (b_lane_q[0]) mem[b_addr_q][LANE_W-1:0]      <= b_wd_q[LANE_W-1:0];
        if (b_lane_q[1]) mem[b_addr_q][WORD_W-1:LANE_W] <= b_wd_q[WORD_W-1:LANE_W];
      end
      if (a_tog != a_ack) begin
        a_ack <= a_tog;
        if (a_lane_q[0]) mem[a_addr_q][LANE_W-1:0]      <= a_wd_q[LANE_W-1:0];
        if (a_lane_q[1]) mem[a_addr_q][WORD_W-1:LANE_W] <= a_wd_q[WORD_W-1:LANE_W];
      end
    end
  end

  assign a_drv_lo = a_ovld[0] & ~a_oe_n;
  assign a_drv_hi = a_ovld[1] & ~a_oe_n;
  assign b_drv_lo = b_ovld[0] & ~b_oe_n;
  assign b_drv_hi = b_ovld[1] & ~b_oe_n;

  assign a_rdata = {a_oq[WORD_W-1:LANE_W] & {LANE_W{a_drv_hi}}, a_oq[LANE_W-1:0] & {LANE_W{a_drv_lo}}};
  assign b_rdata = {b_oq[WORD_W-1:LANE_W] & {LANE_W{b_drv_hi}}, b_oq[LANE_W-1:0] & {LANE_W{b_drv_lo}}};
endmodule

// File: rtl/dpram_bytelane_chk.sv
module dpram_bytelane_chk #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  localparam int WORD_W = 2 * LANE_W
) (
  input logic              rst_n,
  input logic              a_clk,
  input logic              a_cs0_n,
  input logic              a_cs1,
  input logic              a_rd_wr_n,
  input logic              a_hi_en_n,
  input logic              a_lo_en_n,
  input logic              a_oe_n,
  input logic [WORD_W-1:0] a_rdata,
  input logic              a_drv_lo,
  input logic              a_drv_hi,
  input logic              b_clk,
  input logic              b_cs0_n,
  input logic              b_cs1,
  input logic              b_rd_wr_n,
  input logic              b_hi_en_n,
  input logic              b_lo_en_n,
  input logic              b_oe_n,
  input logic [WORD_W-1:0] b_rdata,
  input logic              b_drv_lo,
  input logic              b_drv_hi
);
  AST_A_DRIVE_NEEDS_SELECT: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_drv_lo || a_drv_hi) |-> $past(!a_cs0_n && a_cs1 && a_rd_wr_n, 2)); // R1
  AST_B_DRIVE_NEEDS_SELECT: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_drv_lo || b_drv_hi) |-> $past(!b_cs0_n && b_cs1 && b_rd_wr_n, 2)); // R1
  AST_A_LO_LANE_ENABLED: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_drv_lo |-> $past(!a_lo_en_n, 2)); // R4
  AST_A_HI_LANE_ENABLED: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_drv_hi |-> $past(!a_hi_en_n, 2)); // R4
  AST_B_LO_LANE_ENABLED: assert property (@(posedge b_clk) disable iff (!rst_n)
    b_drv_lo |-> $past(!b_lo_en_n, 2)); // R4
  AST_B_HI_LANE_ENABLED: assert property (@(posedge b_clk) disable iff (!rst_n)
    b_drv_hi |-> $past(!b_hi_en_n, 2)); // R4
  AST_A_OE_OFF: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_oe_n |-> (!a_drv_lo && !a_drv_hi && a_rdata == '0)); // R5
  AST_B_OE_OFF: assert property (@(posedge b_clk) disable iff (!rst_n)
    b_oe_n |-> (!b_drv_lo && !b_drv_hi && b_rdata == '0)); // R5
  AST_A_WRITE_QUIET: assert property (@(posedge a_clk) disable iff (!rst_n)
    $past(!a_cs0_n && a_cs1 && !a_rd_wr_n, 2) |-> (!a_drv_lo && !a_drv_hi)); // R9
  AST_B_WRITE_QUIET: assert property (@(posedge b_clk) disable iff (!rst_n)
    $past(!b_cs0_n && b_cs1 && !b_rd_wr_n, 2) |-> (!b_drv_lo && !b_drv_hi)); // R9
endmodule

bind dpram_bytelane dpram_bytelane_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/dpram_bytelane_test.sv
module dpram_bytelane_test;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int WW = 18;
  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] SEL = 2'b01;
  localparam logic [1:0] OFF0 = 2'b11;
  localparam logic [1:0] OFF1 = 2'b00;
  localparam logic RD = 1'b1;
  localparam logic WR = 1'b0;
  localparam logic [1:0] BOTH = 2'b00;
  localparam logic [1:0] LO = 2'b10;
  localparam logic [1:0] HI = 2'b01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic a_cs0_n = 1'b1, a_cs1 = 1'b0, a_rd_wr_n = 1'b1, a_hi_en_n = 1'b1, a_lo_en_n = 1'b1, a_oe_n = 1'b0;
  logic b_cs0_n = 1'b1, b_cs1 = 1'b0, b_rd_wr_n = 1'b1, b_hi_en_n = 1'b1, b_lo_en_n = 1'b1, b_oe_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [WW-1:0] a_wdata = '0, b_wdata = '0;
  logic [WW-1:0] a_rdata, b_rdata;
  logic a_drv_lo, a_drv_hi, b_drv_lo, b_drv_hi;

  dpram_bytelane #(.ADDR_W(AW), .LANE_W(LW)) uut (
    .rst_n(rst_n),
    .a_clk(clk), .a_cs0_n(a_cs0_n), .a_cs1(a_cs1), .a_rd_wr_n(a_rd_wr_n),
    .a_hi_en_n(a_hi_en_n), .a_lo_en_n(a_lo_en_n), .a_oe_n(a_oe_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drv_lo(a_drv_lo), .a_drv_hi(a_drv_hi),
    .b_clk(clk), .b_cs0_n(b_cs0_n), .b_cs1(b_cs1), .b_rd_wr_n(b_rd_wr_n),
    .b_hi_en_n(b_hi_en_n), .b_lo_en_n(b_lo_en_n), .b_oe_n(b_oe_n),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drv_lo(b_drv_lo), .b_drv_hi(b_drv_hi)
  );

  typedef struct {
    logic [1:0]    av;
    logic [WW-1:0] ad;
    logic [1:0]    bv;
    logic [WW-1:0] bd;
    string         tag;
  } exp_t;

  exp_t sb[$];
  logic [WW-1:0] model [0:(1<<AW)-1];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] lanes_of(logic [WW-1:0] w, logic [1:0] v);
    return {w[WW-1:LW] & {LW{v[1]}}, w[LW-1:0] & {LW{v[0]}}};
  endfunction

  function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw, logic [1:0] v);
    return {v[1] ? nw[WW-1:LW] : old[WW-1:LW], v[0] ? nw[LW-1:0] : old[LW-1:0]};
  endfunction

  task automatic monitor();
    exp_t e;
    if (sb.size() >= 2) begin
      e = sb.pop_front();
      check(e.tag, "A lanes", {30'd0, a_drv_hi, a_drv_lo}, {30'd0, e.av});
      check(e.tag, "A data", {14'd0, a_rdata}, {14'd0, e.ad});
      check(e.tag, "B lanes", {30'd0, b_drv_hi, b_drv_lo}, {30'd0, e.bv});
      check(e.tag, "B data", {14'd0, b_rdata}, {14'd0, e.bd});
    end
  endtask

  task automatic step(string tag,
                      logic [1:0] acs, logic arw, logic [1:0] abe, logic [AW-1:0] aad, logic [WW-1:0] awd,
                      logic [1:0] bcs, logic brw, logic [1:0] bbe, logic [AW-1:0] bad, logic [WW-1:0] bwd);
    exp_t e;
    @(negedge clk);
    monitor();
    e.tag = tag;
    e.av = (!acs[1] && acs[0] && arw) ? ~abe : 2'b00;
    e.bv = (!bcs[1] && bcs[0] && brw) ? ~bbe : 2'b00;
    e.ad = lanes_of(model[aad], e.av);
    e.bd = lanes_of(model[bad], e.bv);
    if (!bcs[1] && bcs[0] && !brw) model[bad] = merge(model[bad], bwd, ~bbe);
    if (!acs[1] && acs[0] && !arw) model[aad] = merge(model[aad], awd, ~abe);
    {a_cs0_n, a_cs1} = acs; a_rd_wr_n = arw; {a_hi_en_n, a_lo_en_n} = abe; a_addr = aad; a_wdata = awd;
    {b_cs0_n, b_cs1} = bcs; b_rd_wr_n = brw; {b_hi_en_n, b_lo_en_n} = bbe; b_addr = bad; b_wdata = bwd;
    sb.push_back(e);
  endtask

  task automatic idle();
    step("R9", OFF0, RD, BOTH, '0, '0, OFF0, RD, BOTH, '0, '0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "A lanes in reset", {30'd0, a_drv_hi, a_drv_lo}, 32'd0);
    check("R8", "B data in reset", {14'd0, b_rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "A data after reset", {14'd0, a_rdata}, 32'd0);
    check("R8", "B lanes after reset", {30'd0, b_drv_hi, b_drv_lo}, 32'd0);

    // R2 full-word writes from both ports, then cross reads (R6, R3)
    step("R2", SEL, WR, BOTH, 8'd5, 18'h12345, SEL, WR, BOTH, 8'd9, 18'h3ABCD);
    step("R3", SEL, RD, BOTH, 8'd9, '0, SEL, RD, BOTH, 8'd5, '0);
    // R2 single-lane writes
    step("R2", SEL, WR, LO, 8'd5, 18'h000EE, SEL, WR, HI, 8'd9, 18'h15500);
    step("R2", SEL, RD, BOTH, 8'd5, '0, SEL, RD, BOTH, 8'd9, '0);
    // R4 partial-lane reads
    step("R4", SEL, RD, HI, 8'd5, '0, SEL, RD, LO, 8'd9, '0);
    // R1 deselected writes via each chip select, and deselected reads
    step("R1", OFF0, WR, BOTH, 8'd5, 18'h3FFFF, OFF1, WR, BOTH, 8'd9, 18'h00000);
    step("R1", OFF1, RD, BOTH, 8'd5, '0, OFF0, RD, BOTH, 8'd9, '0);
    step("R1", SEL, RD, BOTH, 8'd5, '0, SEL, RD, BOTH, 8'd9, '0);
    // R7 same-address collisions
    step("R7", SEL, WR, BOTH, 8'd20, 18'h11111, SEL, WR, BOTH, 8'd20, 18'h22222);
    step("R7", SEL, WR, LO, 8'd21, 18'h0A0A5, SEL, WR, HI, 8'd21, 18'h2C3C3);
    step("R7", SEL, RD, BOTH, 8'd20, '0, SEL, RD, BOTH, 8'd21, '0);
    // R6 read on the edge of the other port's write returns old, next edge new
    step("R6", SEL, WR, BOTH, 8'd30, 18'h00001, OFF0, RD, BOTH, '0, '0);
    step("R6", SEL, WR, BOTH, 8'd30, 18'h33333, SEL, RD, BOTH, 8'd30, '0);
    step("R6", OFF0, RD, BOTH, '0, '0, SEL, RD, BOTH, 8'd30, '0);
    // R6 and R9 same-port write then read back-to-back
    step("R9", SEL, WR, BOTH, 8'd40, 18'h2468A, SEL, WR, LO, 8'd41, 18'h00177);
    step("R6", SEL, RD, BOTH, 8'd40, '0, SEL, RD, LO, 8'd41, '0);
    for (int i = 0; i < 16; i++) begin
      step("R6", SEL, WR, BOTH, 8'(100 + i), 18'(i * 4099 + 7),
           SEL, RD, BOTH, (i == 0) ? 8'd5 : 8'(99 + i), '0);
    end
    for (int i = 0; i < 8; i++) begin
      step("R4", SEL, RD, (i % 2 == 0) ? LO : HI, 8'(100 + i), '0,
           SEL, RD, (i % 3 == 0) ? BOTH : HI, 8'(108 + i), '0);
    end
    idle();
    idle();
    idle();

    // R5 asynchronous output enable on port A
    @(negedge clk);
    a_cs0_n = 1'b0; a_cs1 = 1'b1; a_rd_wr_n = 1'b1; a_hi_en_n = 1'b0; a_lo_en_n = 1'b0; a_addr = 8'd20;
    @(negedge clk);
    a_cs0_n = 1'b1;
    @(negedge clk);
    check("R3", "A word before oe", {14'd0, a_rdata}, {14'd0, model[20]});
    a_oe_n = 1'b1;
    #1;
    check("R5", "A lanes with oe high", {30'd0, a_drv_hi, a_drv_lo}, 32'd0);
    check("R5", "A data with oe high", {14'd0, a_rdata}, 32'd0);
    a_oe_n = 1'b0;
    #1;
    check("R5", "A data after oe low", {14'd0, a_rdata}, {14'd0, model[20]});

    summary();
    $finish;
  end
endmodule